// File: doc/BRIEF.md
# Software Interrupt Dispatcher

This block turns a processor's write to the software-interrupt generation register into pending inter-processor interrupt bits for a cluster of up to eight CPUs. Each write names the writing (source) CPU and carries a 32-bit data word. The block decodes the interrupt number, the filter that selects the targets and the 8-bit target list from that word. It then sets one pending bit for every (interrupt, target CPU, source CPU) triple the write selects.

Pending state is kept separately for each source. If two CPUs raise the same interrupt towards the same target, the block holds two events, and the target must acknowledge them one at a time. A priority arbiter reads a registered summary with one bit per (target CPU, interrupt): that bit is set when the interrupt is pending from any source. The acknowledge path sends a target and an interrupt number. The block clears one source for that pair and reports which source it cleared.

Top module: `sgi_dispatch`

## Requirements
- R1: After reset, and after any later reset, every `pend_any` bit and `ack_done` are 0.
- R2: Write word fields: interrupt number in bits [3:0], target list in bits [23:16], filter in bits [25:24]. All other bits are ignored. Filter 0 makes the interrupt pending at every configured CPU whose bit is set in the target list. `pend_any` shows the result one cycle after the write.
- R3: Filter 1 makes the interrupt pending at every configured CPU except the writer. The target list is ignored.
- R4: Filter 2 makes the interrupt pending only at the writer. The target list is ignored.
- R5: Filter 3 is reserved. A write that uses it changes no pending state.
- R6: Targets numbered NUM_CPU or above are dropped. A write whose source number is NUM_CPU or above changes no pending state.
- R7: `pend_any` bit (cpu*NUM_SGI + id) is 1 exactly when interrupt `id` is pending at `cpu` from at least one source.
- R8: An acknowledge for (cpu, id) clears the lowest-numbered pending source for that pair. The next cycle, `ack_done`=1 and `ack_src` is that source. Raises from two sources need two acknowledges. `pend_any` stays set until the last source is cleared.
- R9: An acknowledge for a pair with nothing pending gives `ack_done`=0 the next cycle and changes no state.
- R10: If a write sets the same (interrupt, target, source) bit that an acknowledge clears in the same cycle, the write wins and the bit stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gen_valid | input | 1 | Generation register write strobe |
| gen_cpu | input | 3 | Number of the writing (source) CPU |
| gen_data | input | 32 | Generation register write data |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_cpu | input | 3 | Acknowledging target CPU |
| ack_id | input | ID_W | Interrupt number being acknowledged |
| pend_any | output | NUM_CPU*NUM_SGI | Registered per-target, per-interrupt pending summary |
| ack_done | output | 1 | Registered: last acknowledge cleared a source |
| ack_src | output | 3 | Registered: source cleared by the last acknowledge |

## Verification
Every result is due exactly one clock edge after its stimulus. A write appears in `pend_any`, and an acknowledge appears in `ack_done` and `ack_src` (with its effect on `pend_any`), after the edge that captures the strobe. The bench drives each strobe on a falling edge, holds it across exactly one rising edge, and samples at the next falling edge, where that single register stage has just updated. The vector table and the directed cases all keep to this timing, including the same-cycle write and acknowledge.

// File: rtl/sgi_pkg.sv
package sgi_pkg;

  localparam int MAX_CPU = 8;
  localparam int CPU_W   = 3;
  localparam int SLOT_W  = MAX_CPU * MAX_CPU;

  localparam int F_ID_LSB   = 0;
  localparam int F_LIST_LSB = 16;
  localparam int F_TYPE_LSB = 24;

  typedef enum logic [1:0] {
    LT_LISTED = 2'd0,
    LT_OTHERS = 2'd1,
    LT_SELF   = 2'd2,
    LT_RSVD   = 2'd3
  } list_type_e;

  typedef logic [MAX_CPU-1:0] cpu_mask_t;
  typedef logic [SLOT_W-1:0]  slot_vec_t;

  // One bit per source for target CPU 0; shift left by a target number to
  // select that target's column.
  function automatic slot_vec_t src_column();
    slot_vec_t col;
    col = '0;
    for (int i = 0; i < MAX_CPU; i++) col[i*MAX_CPU] = 1'b1;
    return col;
  endfunction

endpackage

// File: rtl/sgi_decode.sv
module sgi_decode
  import sgi_pkg::*;
#(
  parameter int NUM_CPU = 8,
  parameter int NUM_SGI = 16,
  parameter int ID_W    = $clog2(NUM_SGI)
) (
  input  logic             wr_valid,
  input  logic [CPU_W-1:0] wr_src,
  input  logic [31:0]      wr_data,
  output logic             set_valid,
  output logic [ID_W-1:0]  set_id,
  output slot_vec_t        set_slots
);

  cpu_mask_t  cfg_mask;
  cpu_mask_t  src_oh;
  cpu_mask_t  tmask;
  list_type_e ltype;
  logic       src_ok;
  logic       unused_bits;

  genvar g;
  generate
    for (g = 0; g < MAX_CPU; g++) begin : g_cfg
      assign cfg_mask[g] = (g < NUM_CPU);
    end
  endgenerate

  assign unused_bits = ^{wr_data[31:F_TYPE_LSB+2], wr_data[F_LIST_LSB-1:ID_W]};

  always_comb begin
    ltype  = list_type_e'(wr_data[F_TYPE_LSB +: 2]);
    src_ok = (int'(wr_src) < NUM_CPU);
    src_oh = cpu_mask_t'(1) << wr_src;
    case (ltype)
      LT_LISTED: tmask = wr_data[F_LIST_LSB +: MAX_CPU];
      LT_OTHERS: tmask = ~src_oh;
      LT_SELF:   tmask = src_oh;
      default:   tmask = '0;
    endcase
    tmask = tmask & cfg_mask;
    if (!src_ok) tmask = '0;
    set_id    = wr_data[F_ID_LSB +: ID_W];
    set_slots = slot_vec_t'(tmask) << {wr_src, 3'b000};
    set_valid = wr_valid && (|tmask);
  end

endmodule

// File: rtl/sgi_pick.sv
module sgi_pick
  import sgi_pkg::*;
#(
  parameter int NUM_SGI = 16,
  parameter int ID_W    = $clog2(NUM_SGI)
) (
  input  slot_vec_t        pend [NUM_SGI],
  input  logic             req_valid,
  input  logic [CPU_W-1:0] req_cpu,
  input  logic [ID_W-1:0]  req_id,
  output logic             hit,
  output logic [CPU_W-1:0] hit_src,
  output slot_vec_t        clr_slots
);

  slot_vec_t row;
  cpu_mask_t col;

  always_comb begin
    row = pend[req_id];
    for (int k = 0; k < MAX_CPU; k++) col[k] = row[k*MAX_CPU + int'(req_cpu)];
    hit_src = '0;
    for (int k = MAX_CPU - 1; k >= 0; k--) begin
      if (col[k]) hit_src = CPU_W'(k);
    end
    hit       = req_valid && (|col);
    clr_slots = hit ? (slot_vec_t'(1) << {hit_src, req_cpu}) : '0;
  end

endmodule

// File: rtl/sgi_store.sv
module sgi_store
  import sgi_pkg::*;
#(
  parameter int NUM_CPU = 8,
  parameter int NUM_SGI = 16,
  parameter int ID_W    = $clog2(NUM_SGI)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       set_valid,
  input  logic [ID_W-1:0]            set_id,
  input  slot_vec_t                  set_slots,
  input  logic                       clr_valid,
  input  logic [ID_W-1:0]            clr_id,
  input  slot_vec_t                  clr_slots,
  output slot_vec_t                  pend_q [NUM_SGI],
  output logic [NUM_CPU*NUM_SGI-1:0] any_q
);

  localparam slot_vec_t COL0 = src_column();

  slot_vec_t                  pend_nxt [NUM_SGI];
  logic [NUM_CPU*NUM_SGI-1:0] any_nxt;

  genvar s, c;
  generate
    for (s = 0; s < NUM_SGI; s++) begin : g_sgi
      always_comb begin
        pend_nxt[s] = pend_q[s];
        if (clr_valid && clr_id == ID_W'(s)) pend_nxt[s] = pend_nxt[s] & ~clr_slots;
        if (set_valid && set_id == ID_W'(s)) pend_nxt[s] = pend_nxt[s] | set_slots;
      end

      always_ff @(posedge clk) begin
        if (rst) pend_q[s] <= '0;
        else     pend_q[s] <= pend_nxt[s];
      end

      for (c = 0; c < NUM_CPU; c++) begin : g_cpu
        assign any_nxt[c*NUM_SGI + s] = |(pend_nxt[s] & (COL0 << c));
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) any_q <= '0;
    else     any_q <= any_nxt;
  end

  // R8: the acknowledge path only ever clears a bit that is currently held.
  p_clear_held_r8: assert property (@(posedge clk) disable iff (rst)
    clr_valid |-> ((pend_q[clr_id] & clr_slots) != '0 && $onehot0(clr_slots)));

endmodule

// File: rtl/sgi_dispatch.sv
module sgi_dispatch
  import sgi_pkg::*;
#(
  parameter int NUM_CPU = 8,
  parameter int NUM_SGI = 16,
  parameter int ID_W    = $clog2(NUM_SGI)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       gen_valid,
  input  logic [2:0]                 gen_cpu,
  input  logic [31:0]                gen_data,
  input  logic                       ack_valid,
  input  logic [2:0]                 ack_cpu,
  input  logic [ID_W-1:0]            ack_id,
  output logic [NUM_CPU*NUM_SGI-1:0] pend_any,
  output logic                       ack_done,
  output logic [2:0]                 ack_src
);

  logic             set_valid;
  logic [ID_W-1:0]  set_id;
  slot_vec_t        set_slots;
  slot_vec_t        pend_q [NUM_SGI];
  logic             hit;
  logic [CPU_W-1:0] hit_src;
  slot_vec_t        clr_slots;

  sgi_decode #(.NUM_CPU(NUM_CPU), .NUM_SGI(NUM_SGI), .ID_W(ID_W)) u_decode (
    .wr_valid (gen_valid),
    .wr_src   (gen_cpu),
    .wr_data  (gen_data),
    .set_valid(set_valid),
    .set_id   (set_id),
    .set_slots(set_slots)
  );

  sgi_pick #(.NUM_SGI(NUM_SGI), .ID_W(ID_W)) u_pick (
    .pend     (pend_q),
    .req_valid(ack_valid),
    .req_cpu  (ack_cpu),
    .req_id   (ack_id),
    .hit      (hit),
    .hit_src  (hit_src),
    .clr_slots(clr_slots)
  );

  sgi_store #(.NUM_CPU(NUM_CPU), .NUM_SGI(NUM_SGI), .ID_W(ID_W)) u_store (
    .clk      (clk),
    .rst      (rst),
    .set_valid(set_valid),
    .set_id   (set_id),
    .set_slots(set_slots),
    .clr_valid(hit),
    .clr_id   (ack_id),
    .clr_slots(clr_slots),
    .pend_q   (pend_q),
    .any_q    (pend_any)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_done <= 1'b0;
      ack_src  <= '0;
    end else begin
      ack_done <= hit;
      ack_src  <= hit ? hit_src : '0;
    end
  end

  // Port-level checks.
  logic ack_seen;
  always_comb begin
    ack_seen = 1'b0;
    if (int'(ack_cpu) < NUM_CPU) ack_seen = pend_any[int'(ack_cpu)*NUM_SGI + int'(ack_id)];
  end

  logic [1:0] gen_type;
  assign gen_type = gen_data[F_TYPE_LSB +: 2];

  p_rsvd_ignored_r5: assert property (@(posedge clk) disable iff (rst)
    (gen_valid && gen_type == 2'd3 && !ack_valid) |=> $stable(pend_any));

  p_self_sets_r4: assert property (@(posedge clk) disable iff (rst)
    (gen_valid && gen_type == 2'd2 && int'(gen_cpu) < NUM_CPU) |=>
      pend_any[int'($past(gen_cpu))*NUM_SGI + int'($past(gen_data[ID_W-1:0]))]);

  p_ack_empty_r9: assert property (@(posedge clk) disable iff (rst)
    (ack_valid && !ack_seen) |=> !ack_done);

  p_ack_src_range_r8: assert property (@(posedge clk) disable iff (rst)
    ack_done |-> (int'(ack_src) < NUM_CPU));

endmodule

// File: tb/sgi_dispatch_tb.sv
module sgi_dispatch_tb;

  localparam int NCPU = 6;
  localparam int NSGI = 16;
  localparam int W    = NCPU * NSGI;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         gen_valid = 1'b0;
  logic [2:0]   gen_cpu = '0;
  logic [31:0]  gen_data = '0;
  logic         ack_valid = 1'b0;
  logic [2:0]   ack_cpu = '0;
  logic [3:0]   ack_id = '0;
  logic [W-1:0] pend_any;
  logic         ack_done;
  logic [2:0]   ack_src;

  int total = 0;
  int bad   = 0;
  bit ended = 0;

  always #2 clk = ~clk;

  sgi_dispatch #(.NUM_CPU(NCPU), .NUM_SGI(NSGI)) u_dut (
    .clk(clk), .rst(rst),
    .gen_valid(gen_valid), .gen_cpu(gen_cpu), .gen_data(gen_data),
    .ack_valid(ack_valid), .ack_cpu(ack_cpu), .ack_id(ack_id),
    .pend_any(pend_any), .ack_done(ack_done), .ack_src(ack_src)
  );

  typedef struct packed {
    logic [2:0]  src;
    logic [31:0] data;
    logic [7:0]  exp;
  } vec_t;

  // data = filter<<24 | list<<16 | id ; exp = target mask expected
  localparam vec_t VEC [0:7] = '{
    '{3'd0, 32'h0005_0003, 8'h05},  // R2 listed
    '{3'd2, 32'h00F0_0007, 8'h30},  // R6 targets 6,7 dropped
    '{3'd1, 32'h0100_0000, 8'h3D},  // R3 all but writer
    '{3'd5, 32'hFD00_ABCF, 8'h1F},  // R3 with noise bits, R2 ignored bits
    '{3'd4, 32'h02FF_0009, 8'h10},  // R4 self only
    '{3'd3, 32'h03FF_0002, 8'h00},  // R5 reserved
    '{3'd0, 32'h0000_0001, 8'h00},  // R2 empty list
    '{3'd7, 32'h0200_0004, 8'h00}   // R6 source out of range
  };

  function automatic string vec_tag(int i);
    case (i)
      0, 6: return "R2";
      1, 7: return "R6";
      2, 3: return "R3";
      4:    return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    gen_valid = 1'b0; ack_valid = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; idle();
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic gen(input logic [2:0] src, input logic [31:0] d);
    gen_valid = 1'b1; gen_cpu = src; gen_data = d;
    @(negedge clk);
    idle();
  endtask

  task automatic ack(input logic [2:0] cpu, input logic [3:0] id);
    ack_valid = 1'b1; ack_cpu = cpu; ack_id = id;
    @(negedge clk);
    idle();
  endtask

  function automatic logic [W-1:0] bit_at(int cpu, int id);
    logic [W-1:0] v;
    v = '0;
    v[cpu*NSGI + id] = 1'b1;
    return v;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!ended) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] expv;
    do_reset();
    // R1 reset state
    check(pend_any == '0 && !ack_done, "R1 reset", {ack_done, pend_any}, '0);

    // Vector table: each entry from a clean state, result due one edge later.
    for (int i = 0; i < 8; i++) begin
      do_reset();
      gen(VEC[i].src, VEC[i].data);
      expv = '0;
      for (int c = 0; c < NCPU; c++)
        if (VEC[i].exp[c]) expv = expv | bit_at(c, int'(VEC[i].data[3:0]));
      check(pend_any == expv, {vec_tag(i), "/R7 vector"}, pend_any, expv);
    end

    // R8: two sources for the same target and interrupt
    do_reset();
    gen(3'd3, 32'h0004_0005);
    gen(3'd1, 32'h0004_0005);
    check(pend_any == bit_at(2, 5), "R7 two sources", pend_any, bit_at(2, 5));
    ack(3'd2, 4'd5);
    check(ack_done && ack_src == 3'd1, "R8 first ack lowest source", {ack_done, ack_src}, {1'b1, 3'd1});
    check(pend_any == bit_at(2, 5), "R8 still pending", pend_any, bit_at(2, 5));
    ack(3'd2, 4'd5);
    check(ack_done && ack_src == 3'd3, "R8 second ack", {ack_done, ack_src}, {1'b1, 3'd3});
    check(pend_any == '0, "R8 drained", pend_any, '0);
    ack(3'd2, 4'd5);
    check(!ack_done, "R9 ack on empty", ack_done, 1'b0);
    check(pend_any == '0, "R9 no state change", pend_any, '0);
    ack(3'd6, 4'd0);
    check(!ack_done, "R9 ack beyond cpu count", ack_done, 1'b0);

    // R10: same-cycle set and clear of one slot
    gen(3'd0, 32'h0002_0006);
    ack_valid = 1'b1; ack_cpu = 3'd1; ack_id = 4'd6;
    gen(3'd0, 32'h0002_0006);
    check(ack_done && ack_src == 3'd0, "R10 ack reported", {ack_done, ack_src}, {1'b1, 3'd0});
    check(pend_any == bit_at(1, 6), "R10 write wins", pend_any, bit_at(1, 6));
    ack(3'd1, 4'd6);
    check(ack_done && pend_any == '0, "R10 single event left", {ack_done, pend_any}, {1'b1, {W{1'b0}}});

    // R5 reserved filter leaves existing state untouched
    gen(3'd2, 32'h0000_0000 | 32'h0100_000A);
    expv = '0;
    for (int c = 0; c < NCPU; c++) if (c != 2) expv = expv | bit_at(c, 10);
    check(pend_any == expv, "R3 others", pend_any, expv);
    gen(3'd2, 32'h03FF_000A);
    check(pend_any == expv, "R5 reserved no change", pend_any, expv);

    // R1 reset clears held state
    do_reset();
    check(pend_any == '0 && !ack_done, "R1 reset clears", {ack_done, pend_any}, '0);

    ended = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule